// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

`zt_sram` is a synthesizable model of a synchronous static RAM whose data bus never needs an idle cycle when traffic switches between reads and writes. Commands, addresses and byte enables are registered on the rising clock edge. Write data is taken a fixed number of edges after its command. That delay matches the read latency, so a read and a write can be issued on consecutive edges and their data phases still fall into consecutive bus cycles.

A static mode input selects the timing. In registered-output (pipelined) mode, read data passes through an output register and the write-data delay is two edges. In flow-through mode, read data comes straight from the array in the cycle after the command and the write-data delay is one edge. A four-beat burst counter continues a burst when an advance input is set. The burst runs in linear or interleaved order and wraps inside its aligned four-word block.

Writes are per 9-bit byte. Every enabled written byte is checked for even or odd parity. The bidirectional data bus is modelled as separate input, output and output-enable signals. An asynchronous output-enable input can float the bus at any moment.

Top module: `zt_sram`

## Requirements
- R1: A new command is accepted only on an edge where adv_i=0, ce1_ni=0, ce2_i=1 and ce3_ni=0. On any other non-advance edge the block is deselected: nothing is written and the bus is not driven for that command.
- R2: With pipe_mode_i=0 (flow-through), read data for a command sampled at edge k is driven, with dq_oe_o=1, during the cycle between edges k and k+1.
- R3: With pipe_mode_i=1 (pipelined), read data for a command sampled at edge k is driven, with dq_oe_o=1, during the cycle between edges k+1 and k+2. dq_oe_o is 0 between edges k and k+1.
- R4: Write data for a command at edge k is taken from dq_i at edge k+2 in pipelined mode and at edge k+1 in flow-through mode. Reads and writes issued on consecutive edges need no idle cycles, and the bus is never driven while write data is being taken.
- R5: A read returns the contents after all earlier write commands, including a write issued on the edge immediately before it.
- R6: Byte b occupies dq bits 9b+8 down to 9b. It is written only when bw_ni[b]=0 on the command's edge; the other bytes keep their values.
- R7: With linear_i=1, beat n of a burst (n=0..3) uses low address bits (start+n) mod 4. The upper address bits stay fixed.
- R8: With linear_i=0, beat n of a burst uses low address bits start XOR n.
- R9: adv_i=1 continues the active burst as the same read or write type, ignoring we_ni and the chip enables. After the fourth beat the burst wraps to the start word. adv_i=1 with no active burst is a deselect.
- R10: par_err_o is 1 for the single cycle after a write-data edge if any enabled byte has XOR of its 9 bits different from par_odd_i (1 = odd, 0 = even parity). The data is written regardless, and disabled bytes are not checked.
- R11: oe_ni=1 forces dq_oe_o to 0 at once, without a clock edge. Whenever dq_oe_o is 0, dq_o is 0.
- R12: After reset, dq_oe_o and par_err_o are 0 and no command is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pipe_mode_i | input | 1 | 1 = registered output, 0 = flow-through (static) |
| linear_i | input | 1 | 1 = linear burst order, 0 = interleaved (static) |
| par_odd_i | input | 1 | 1 = odd parity expected, 0 = even |
| ce1_ni | input | 1 | Chip enable, active low |
| ce2_i | input | 1 | Chip enable, active high |
| ce3_ni | input | 1 | Chip enable, active low |
| adv_i | input | 1 | Continue current burst |
| we_ni | input | 1 | 0 = write command, 1 = read command |
| bw_ni | input | N_BYTES | Per-byte write enable, active low |
| addr_i | input | ADDR_W | Word address |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| dq_i | input | N_BYTES*BYTE_W | Write data from the bus |
| dq_o | output | N_BYTES*BYTE_W | Read data to the bus |
| dq_oe_o | output | 1 | Bus drive enable |
| par_err_o | output | 1 | Write parity error pulse |

## Verification
The assertions check the following on every cycle:
- a deselect edge never produces a command;
- the burst counter wraps after the fourth beat;
- an advanced beat keeps the type of the beat before it;
- a parity pulse only follows a real write-data edge;
- a pipelined read drives the bus one cycle after its array access;
- the bus is never driven while write data is being taken.

Only the bench's scenarios can show the data values. These include:
- read-after-write forwarding across back-to-back commands;
- byte merging;
- the exact address sequence of linear and interleaved bursts, including the wrap;
- data stored despite a parity error;
- the asynchronous release and recapture of the bus by the output enable.

// File: rtl/zt_sram_pkg.sv
`timescale 1ns/1ps
package zt_sram_pkg;
  localparam int unsigned BURST_LEN = 4;
  localparam int unsigned BCNT_W    = $clog2(BURST_LEN);

  // low address bits of beat idx for a burst starting at start
  function automatic logic [BCNT_W-1:0] beat_low(input logic [BCNT_W-1:0] start,
                                                 input logic [BCNT_W-1:0] idx,
                                                 input logic              linear);
    logic [BCNT_W-1:0] sum;
    sum = start + idx;
    return linear ? sum : (start ^ idx);
  endfunction
endpackage

// File: rtl/zt_cmd_seq.sv
`timescale 1ns/1ps
module zt_cmd_seq
  import zt_sram_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned N_BYTES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               linear_i,
  input  logic               adv_i,
  input  logic               ce1_ni,
  input  logic               ce2_i,
  input  logic               ce3_ni,
  input  logic               we_ni,
  input  logic [N_BYTES-1:0] bw_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic               vld_o,
  output logic               wr_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [N_BYTES-1:0] bwe_o
);
  localparam int unsigned HI_W = ADDR_W - BCNT_W;

  logic              live_q, bwr_q;
  logic [ADDR_W-1:0] start_q;
  logic [BCNT_W-1:0] cnt_q, cnt_nx;
  logic              sel, new_cmd, cont;
  logic [ADDR_W-1:0] beat_addr;

  assign sel     = !ce1_ni && ce2_i && !ce3_ni;
  assign new_cmd = !adv_i && sel;
  assign cont    = adv_i && live_q;
  assign cnt_nx  = cnt_q + 1'b1;

  always_comb begin
    if (new_cmd) beat_addr = addr_i;
    else beat_addr = {start_q[ADDR_W-1 -: HI_W], beat_low(start_q[BCNT_W-1:0], cnt_nx, linear_i)};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q  <= 1'b0;
      bwr_q   <= 1'b0;
      start_q <= '0;
      cnt_q   <= '0;
    end else if (new_cmd) begin
      live_q  <= 1'b1;
      bwr_q   <= !we_ni;
      start_q <= addr_i;
      cnt_q   <= '0;
    end else if (cont) begin
      cnt_q   <= cnt_nx;
    end else begin
      live_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      wr_o   <= 1'b0;
      addr_o <= '0;
      bwe_o  <= '0;
    end else begin
      vld_o  <= new_cmd || cont;
      wr_o   <= new_cmd ? !we_ni : bwr_q;
      addr_o <= beat_addr;
      bwe_o  <= ~bw_ni;
    end
  end

  AST_DESEL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !sel) |=> !vld_o); // R1
  AST_BURST_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cont && cnt_q == BCNT_W'(BURST_LEN-1)) |=> (cnt_q == '0)); // R9
  AST_ADV_SAME_TYPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cont |=> (vld_o && wr_o == $past(wr_o))); // R9
endmodule

// File: rtl/zt_par_chk.sv
`timescale 1ns/1ps
module zt_par_chk #(
  parameter int unsigned N_BYTES = 2,
  parameter int unsigned BYTE_W  = 9
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       odd_i,
  input  logic                       chk_en_i,
  input  logic [N_BYTES-1:0]         bwe_i,
  input  logic [N_BYTES*BYTE_W-1:0]  data_i,
  output logic                       err_o
);
  logic [N_BYTES-1:0] bad;

  for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
    assign bad[b] = bwe_i[b] && ((^data_i[b*BYTE_W +: BYTE_W]) != odd_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else         err_o <= chk_en_i && (|bad);
  end

  AST_PAR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(chk_en_i)); // R10
endmodule

// File: rtl/zt_sram.sv
`timescale 1ns/1ps
module zt_sram #(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned N_BYTES = 2,
  parameter int unsigned BYTE_W  = 9
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      pipe_mode_i,
  input  logic                      linear_i,
  input  logic                      par_odd_i,
  input  logic                      ce1_ni,
  input  logic                      ce2_i,
  input  logic                      ce3_ni,
  input  logic                      adv_i,
  input  logic                      we_ni,
  input  logic [N_BYTES-1:0]        bw_ni,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic                      oe_ni,
  input  logic [N_BYTES*BYTE_W-1:0] dq_i,
  output logic [N_BYTES*BYTE_W-1:0] dq_o,
  output logic                      dq_oe_o,
  output logic                      par_err_o
);
  localparam int unsigned DW    = N_BYTES * BYTE_W;
  localparam int unsigned DEPTH = 1 << ADDR_W;

  // stage 0: command registered at edge k
  logic               s0_vld, s0_wr;
  logic [ADDR_W-1:0]  s0_addr;
  logic [N_BYTES-1:0] s0_bwe;
  // stage 1: same command one edge later (pipelined write slot)
  logic               s1_vld, s1_wr;
  logic [ADDR_W-1:0]  s1_addr;
  logic [N_BYTES-1:0] s1_bwe;

  logic               w_vld;
  logic [ADDR_W-1:0]  w_addr;
  logic [N_BYTES-1:0] w_bwe;

  logic [DW-1:0]      mem_q [DEPTH];
  logic [DW-1:0]      rd_raw, rd_fwd, out_q, rd_data;
  logic               out_vld_q, byp, rd_live;

  zt_cmd_seq #(.ADDR_W(ADDR_W), .N_BYTES(N_BYTES)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .linear_i(linear_i),
    .adv_i   (adv_i),
    .ce1_ni  (ce1_ni),
    .ce2_i   (ce2_i),
    .ce3_ni  (ce3_ni),
    .we_ni   (we_ni),
    .bw_ni   (bw_ni),
    .addr_i  (addr_i),
    .vld_o   (s0_vld),
    .wr_o    (s0_wr),
    .addr_o  (s0_addr),
    .bwe_o   (s0_bwe)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld  <= 1'b0;
      s1_wr   <= 1'b0;
      s1_addr <= '0;
      s1_bwe  <= '0;
    end else begin
      s1_vld  <= s0_vld;
      s1_wr   <= s0_wr;
      s1_addr <= s0_addr;
      s1_bwe  <= s0_bwe;
    end
  end

  // late-write slot depends on mode
  assign w_vld  = pipe_mode_i ? (s1_vld && s1_wr) : (s0_vld && s0_wr);
  assign w_addr = pipe_mode_i ? s1_addr : s0_addr;
  assign w_bwe  = pipe_mode_i ? s1_bwe  : s0_bwe;

  always_ff @(posedge clk_i) begin
    for (int b = 0; b < N_BYTES; b++) begin
      if (w_vld && w_bwe[b]) mem_q[w_addr][b*BYTE_W +: BYTE_W] <= dq_i[b*BYTE_W +: BYTE_W];
    end
  end

  assign rd_raw = mem_q[s0_addr];

  // pipelined: write committing at this edge must reach the read loading at this edge
  assign byp = s1_vld && s1_wr && (s1_addr == s0_addr);
  always_comb begin
    rd_fwd = rd_raw;
    for (int b = 0; b < N_BYTES; b++) begin
      if (byp && s1_bwe[b]) rd_fwd[b*BYTE_W +: BYTE_W] = dq_i[b*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q     <= '0;
      out_vld_q <= 1'b0;
    end else begin
      out_q     <= rd_fwd;
      out_vld_q <= s0_vld && !s0_wr;
    end
  end

  assign rd_live = pipe_mode_i ? out_vld_q : (s0_vld && !s0_wr);
  assign rd_data = pipe_mode_i ? out_q : rd_raw;
  assign dq_oe_o = rd_live && !oe_ni;
  assign dq_o    = dq_oe_o ? rd_data : '0;

  zt_par_chk #(.N_BYTES(N_BYTES), .BYTE_W(BYTE_W)) u_par (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .odd_i   (par_odd_i),
    .chk_en_i(w_vld),
    .bwe_i   (w_bwe),
    .data_i  (dq_i),
    .err_o   (par_err_o)
  );

  AST_PIPE_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_mode_i && $past(pipe_mode_i) && $past(s0_vld && !s0_wr) && !oe_ni) |-> dq_oe_o); // R3
  AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_vld |-> !dq_oe_o); // R4
endmodule

// File: tb/zt_sram_tb_top.sv
`timescale 1ns/1ps
module zt_sram_tb_top;
  localparam int K_IDLE = 0, K_NEW = 1, K_ADV = 2;
  localparam logic [2:0] CE_OK = 3'b010; // {ce1_ni, ce2_i, ce3_ni}
  localparam int MAXE = 24;

  logic        clk_i = 0, rst_ni = 0;
  logic        pipe_mode_i = 0, linear_i = 1, par_odd_i = 0;
  logic        ce1_ni = 1, ce2_i = 0, ce3_ni = 1, adv_i = 0, we_ni = 1, oe_ni = 0;
  logic [1:0]  bw_ni = 2'b11;
  logic [7:0]  addr_i = 0;
  logic [17:0] dq_i = 0, dq_o;
  logic        dq_oe_o, par_err_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  logic [17:0] model [256];
  int          k_kind [MAXE];
  logic [2:0]  k_ce   [MAXE];
  logic        k_we   [MAXE];
  logic [1:0]  k_bw   [MAXE];
  logic [7:0]  k_addr [MAXE];
  logic [17:0] k_d    [MAXE];
  logic        e_act  [MAXE];
  logic        e_wr   [MAXE];
  logic [7:0]  e_addr [MAXE];
  int n_ent = 0;

  always #4 clk_i = ~clk_i;

  zt_sram dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .pipe_mode_i(pipe_mode_i), .linear_i(linear_i),
    .par_odd_i(par_odd_i), .ce1_ni(ce1_ni), .ce2_i(ce2_i), .ce3_ni(ce3_ni), .adv_i(adv_i),
    .we_ni(we_ni), .bw_ni(bw_ni), .addr_i(addr_i), .oe_ni(oe_ni), .dq_i(dq_i),
    .dq_o(dq_o), .dq_oe_o(dq_oe_o), .par_err_o(par_err_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [17:0] pd(input logic [7:0] hi, input logic [7:0] lo);
    return {(^hi) ^ par_odd_i, hi, (^lo) ^ par_odd_i, lo};
  endfunction

  function automatic logic [1:0] blow(input logic [1:0] s, input logic [1:0] n, input logic lin);
    logic [1:0] sum;
    sum = s + n;
    return lin ? sum : (s ^ n);
  endfunction

  // drive inputs at a falling edge, return at the next falling edge
  task automatic tick(input logic adv, input logic [2:0] ce, input logic wen,
                      input logic [1:0] bwn, input logic [7:0] a, input logic [17:0] d);
    adv_i = adv; {ce1_ni, ce2_i, ce3_ni} = ce; we_ni = wen; bw_ni = bwn; addr_i = a; dq_i = d;
    @(negedge clk_i);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 3'b110, 1, 2'b11, 8'h00, 18'h0);
  endtask

  task automatic set_mode(input logic pipe, input logic lin, input logic odd);
    idle(3);
    pipe_mode_i = pipe; linear_i = lin; par_odd_i = odd;
    idle(2);
  endtask

  task automatic clr();
    n_ent = 0;
  endtask

  task automatic add(input int kind, input logic [2:0] ce, input logic wen,
                     input logic [1:0] bwn, input logic [7:0] a, input logic [17:0] d);
    k_kind[n_ent] = kind; k_ce[n_ent] = ce; k_we[n_ent] = wen;
    k_bw[n_ent] = bwn; k_addr[n_ent] = a; k_d[n_ent] = d;
    n_ent++;
  endtask

  task automatic aw(input logic [7:0] a, input logic [17:0] d);
    add(K_NEW, CE_OK, 0, 2'b00, a, d);
  endtask
  task automatic ar(input logic [7:0] a);
    add(K_NEW, CE_OK, 1, 2'b00, a, 18'h0);
  endtask
  task automatic av(input logic [17:0] d);
    add(K_ADV, 3'b110, 1, 2'b00, 8'h00, d);
  endtask

  // plays the entries on consecutive edges and checks every bus cycle
  task automatic run_stream(input string tag);
    int dl;
    logic live, bwr;
    logic [7:0] st;
    logic [1:0] cnt;
    string ttag;
    dl = pipe_mode_i ? 2 : 1;
    ttag = pipe_mode_i ? "R3" : "R2";
    live = 0; bwr = 0; st = 0; cnt = 0;
    for (int t = 0; t <= n_ent + dl; t++) begin
      logic a_adv, a_we, exp_oe, exp_par;
      logic [2:0] a_ce;
      logic [1:0] a_bw;
      logic [7:0] a_ad;
      logic [17:0] a_d;
      int j, r;
      a_adv = 0; a_ce = 3'b110; a_we = 1; a_bw = 2'b11; a_ad = 0;
      if (t < n_ent) begin
        a_adv = (k_kind[t] == K_ADV);
        a_ce = k_ce[t]; a_we = k_we[t]; a_bw = k_bw[t]; a_ad = k_addr[t];
        e_act[t] = 0; e_wr[t] = 0; e_addr[t] = 0;
        if (k_kind[t] == K_NEW && k_ce[t] == CE_OK) begin
          live = 1; bwr = !k_we[t]; st = k_addr[t]; cnt = 0;
          e_act[t] = 1; e_wr[t] = bwr; e_addr[t] = k_addr[t];
        end else if (k_kind[t] == K_ADV && live) begin
          cnt = cnt + 1;
          e_act[t] = 1; e_wr[t] = bwr; e_addr[t] = {st[7:2], blow(st[1:0], cnt, linear_i)};
        end else begin
          live = 0;
        end
      end
      j = t - dl;
      a_d = (j >= 0 && j < n_ent && e_act[j] && e_wr[j]) ? k_d[j] : 18'h0;
      tick(a_adv, a_ce, a_we, a_bw, a_ad, a_d);
      exp_par = 0;
      if (j >= 0 && j < n_ent && e_act[j] && e_wr[j]) begin
        for (int b = 0; b < 2; b++) begin
          if (!k_bw[j][b]) begin
            if ((^k_d[j][b*9 +: 9]) != par_odd_i) exp_par = 1;
            model[e_addr[j]][b*9 +: 9] = k_d[j][b*9 +: 9];
          end
        end
      end
      chk({"R10 par ", tag}, 32'(par_err_o), 32'(exp_par));
      r = t - dl + 1;
      exp_oe = (r >= 0 && r < n_ent && e_act[r] && !e_wr[r]);
      chk({ttag, " R4 oe ", tag}, 32'(dq_oe_o), 32'(exp_oe));
      if (exp_oe) chk({"R5 data ", tag}, 32'(dq_o), 32'(model[e_addr[r]]));
      else        chk({"R11 idle bus ", tag}, 32'(dq_o), 32'h0);
    end
  endtask

  task automatic t_reset();
    rst_ni = 0;
    idle(3);
    chk("R12 oe after reset", 32'(dq_oe_o), 32'h0);
    chk("R12 par after reset", 32'(par_err_o), 32'h0);
    rst_ni = 1;
    idle(2);
    chk("R12 still idle", 32'(dq_oe_o), 32'h0);
  endtask

  task automatic t_b2b(input logic pipe);
    set_mode(pipe, 1, 0);
    clr();
    aw(8'h10, pd(8'h11, 8'h22)); ar(8'h10);
    aw(8'h11, pd(8'h33, 8'h44)); ar(8'h11);
    aw(8'h10, pd(8'h55, 8'h66)); ar(8'h10); ar(8'h11);
    aw(8'h12, pd(8'h77, 8'h88)); aw(8'h12, pd(8'h99, 8'hAA)); ar(8'h12);
    run_stream(pipe ? "R4 R5 pipe" : "R4 R5 flow");
  endtask

  task automatic t_bytes(input logic pipe);
    set_mode(pipe, 1, 0);
    clr();
    aw(8'h20, pd(8'hAA, 8'hBB));
    add(K_NEW, CE_OK, 0, 2'b10, 8'h20, pd(8'hCC, 8'hDD)); // R6 byte0 only
    add(K_NEW, CE_OK, 0, 2'b01, 8'h20, pd(8'hEE, 8'hFF)); // R6 byte1 only
    ar(8'h20);
    add(K_NEW, CE_OK, 0, 2'b11, 8'h20, pd(8'h01, 8'h02)); // R6 none
    ar(8'h20);
    run_stream("R6 bytes");
    chk("R6 merged word", 32'(model[8'h20]), 32'(pd(8'hEE, 8'hDD)));
  endtask

  task automatic t_burst_lin();
    set_mode(1, 1, 0);
    clr();
    aw(8'h32, pd(8'h01, 8'h10)); av(pd(8'h02, 8'h20)); av(pd(8'h03, 8'h30)); av(pd(8'h04, 8'h40));
    ar(8'h31); av(0); av(0); av(0); av(0); // R9 fifth beat wraps
    run_stream("R7 R9 linear");
    chk("R7 beat2 lands at 0x30", 32'(model[8'h30]), 32'(pd(8'h03, 8'h30)));
  endtask

  task automatic t_burst_int();
    set_mode(0, 0, 0);
    clr();
    aw(8'h35, pd(8'h05, 8'h50)); av(pd(8'h06, 8'h60)); av(pd(8'h07, 8'h70)); av(pd(8'h08, 8'h80));
    ar(8'h32); av(0); av(0); av(0);
    ar(8'h36); ar(8'h34);
    run_stream("R8 interleaved");
    chk("R8 beat3 lands at 0x36", 32'(model[8'h36]), 32'(pd(8'h08, 8'h80)));
    chk("R8 beat2 lands at 0x37", 32'(model[8'h37]), 32'(pd(8'h07, 8'h70)));
  endtask

  task automatic t_desel();
    set_mode(1, 1, 0);
    clr();
    aw(8'h50, pd(8'h5A, 8'hA5));
    add(K_NEW, 3'b110, 0, 2'b00, 8'h50, pd(8'h00, 8'h01)); // R1 ce1 off
    add(K_NEW, 3'b000, 0, 2'b00, 8'h50, pd(8'h00, 8'h02)); // R1 ce2 off
    add(K_NEW, 3'b011, 0, 2'b00, 8'h50, pd(8'h00, 8'h03)); // R1 ce3 off
    add(K_NEW, 3'b110, 1, 2'b00, 8'h50, 0);                // R1 blocked read
    av(pd(8'h00, 8'h04));                                  // R9 adv without burst
    ar(8'h50);
    run_stream("R1 deselect");
    chk("R1 word kept", 32'(model[8'h50]), 32'(pd(8'h5A, 8'hA5)));
  endtask

  task automatic t_parity(input logic pipe, input logic odd);
    set_mode(pipe, 1, odd);
    clr();
    aw(8'h60, pd(8'h12, 8'h34));
    aw(8'h61, pd(8'h56, 8'h78) ^ 18'h00100);                      // R10 byte0 bad
    add(K_NEW, CE_OK, 0, 2'b10, 8'h62, pd(8'h9A, 8'hBC) ^ 18'h20000); // R10 bad byte disabled
    ar(8'h61); ar(8'h60);
    aw(8'h63, pd(8'hDE, 8'hF0) ^ 18'h20000);                      // R10 byte1 bad
    ar(8'h63);
    run_stream(odd ? "R10 odd" : "R10 even");
  endtask

  task automatic t_oe();
    set_mode(0, 1, 0);
    clr();
    aw(8'h40, pd(8'hC3, 8'h3C));
    run_stream("R11 setup");
    oe_ni = 1;
    tick(0, CE_OK, 1, 2'b11, 8'h40, 0);
    chk("R11 oe forced off", 32'(dq_oe_o), 32'h0);
    chk("R11 dq zero", 32'(dq_o), 32'h0);
    oe_ni = 0; #1;
    chk("R11 async release oe", 32'(dq_oe_o), 32'h1);
    chk("R11 async release data", 32'(dq_o), 32'(model[8'h40]));
    oe_ni = 1; #1;
    chk("R11 async float", 32'(dq_oe_o), 32'h0);
    oe_ni = 0;
    idle(2);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog R12 act=hung exp=done");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    t_reset();
    t_b2b(0);
    t_b2b(1);
    t_bytes(1);
    t_bytes(0);
    t_burst_lin();
    t_burst_int();
    t_desel();
    t_parity(0, 0);
    t_parity(1, 1);
    t_oe();
    done = 1;
    summary();
    $finish;
  end
endmodule